// File: doc/BRIEF.md
# Sub-Dword Operand Select and Merge

This block wraps one 32-bit datapath lane so that the operation inside it can work on bytes and halfwords. On the way in, each of two source words goes through its own extractor. The extractor picks out a byte, a halfword or the whole word and widens the field back to 32 bits, either with zeros or with copies of the field's top bit. On the way out, the raw 32-bit result is written into a chosen byte, halfword or whole-word field of the destination. The bits around that field are filled by one of three policies: cleared, sign-extended above the field with zeros below it, or kept from the old destination value.

The operation between the extractors and the merger is outside this block. By default the block is purely combinational. The parameter `OUT_REG` adds one register stage on all three outputs. That stage uses a synchronous active-low reset.

Top module: `subdword_sel_merge`

## Requirements
- R1: Source select codes, 3 bits wide, choose the field as follows: 0 to 3 pick byte k at bits 8k+7:8k, 4 picks bits 15:0, 5 picks bits 31:16, and 6 picks the whole word. With the sign flag clear, the extracted field is zero-extended to 32 bits.
- R2: With source select 6 (whole word), the operand output equals the source word, whatever the sign flag is.
- R3: With the sign flag set and a byte or halfword select, every bit above the field copies the field's most significant bit.
- R4: The two source paths are independent. Each operand output depends only on its own source word, select and sign flag.
- R5: The destination select uses the same codes as R1. The selected field receives the low bits of the result, truncated to the field width.
- R6: Fill policy 0 (pad) writes zeros in every destination bit outside the selected field.
- R7: Fill policy 1 (sign) copies result bit w-1 into every bit above the field, where w is the field width, and writes zeros below the field.
- R8: Fill policy 2 (keep) passes the old destination bits through unchanged outside the selected field.
- R9: With destination select 6, the destination output equals the result word under every fill policy.
- R10: Select code 7 behaves exactly like code 6, and fill policy 3 behaves exactly like policy 2.
- R11: With OUT_REG=1, every output reflects the inputs sampled at the previous rising clock edge, and a cycle with rst_n low drives all outputs to zero. With OUT_REG=0, the outputs follow the inputs with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| src0_i | input | 32 | First source word |
| src1_i | input | 32 | Second source word |
| sel0_i | input | 3 | Field select for the first source |
| sel1_i | input | 3 | Field select for the second source |
| sext0_i | input | 1 | Sign-extend the first extracted field |
| sext1_i | input | 1 | Sign-extend the second extracted field |
| res_i | input | 32 | Raw result word of the lane operation |
| old_i | input | 32 | Previous destination word |
| dsel_i | input | 3 | Destination field select |
| fill_i | input | 2 | Fill policy for bits outside the destination field |
| op0_o | output | 32 | Extracted first operand |
| op1_o | output | 32 | Extracted second operand |
| dst_o | output | 32 | Merged destination word |

## Verification
The case that is hardest to reach is the sign fill of the destination. In that case the bits below the field must be zero and the bits above it must follow one specific result bit. A result that is too wide for the field, or a field at a nonzero offset, is needed before a wrong fill shows at the ports. The stimulus covers every destination select against every fill policy, including the reserved codes. For each pair it applies several result and old-word patterns. Some patterns have the field's top bit set while the bits above it are clear, and others the reverse. The old word is all ones in some patterns, so a kept region and a zeroed region always differ. Each source select runs with the sign flag both set and clear, on bytes whose top bit is set and on bytes whose top bit is clear.

// File: rtl/sdw_pkg.sv
// Shared types for sub-dword field selection.
// Assumes a 32-bit lane; the field codes are defined against that width.
package sdw_pkg;
    localparam int WORD_W = 32;
    localparam int POS_W  = $clog2(WORD_W);
    localparam int LEN_W  = POS_W + 1;

    typedef enum logic [2:0] {
        SEL_B0   = 3'd0,
        SEL_B1   = 3'd1,
        SEL_B2   = 3'd2,
        SEL_B3   = 3'd3,
        SEL_H0   = 3'd4,
        SEL_H1   = 3'd5,
        SEL_FULL = 3'd6,
        SEL_RSVD = 3'd7
    } sel_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_KEEP = 2'd2,
        FILL_RSVD = 2'd3
    } fill_e;

    typedef struct packed {
        logic [POS_W-1:0] lsb;
        logic [LEN_W-1:0] width;
    } field_t;

    // Map a select code to the field position and width; reserved code acts as whole word.
    function automatic field_t decode_field(input logic [2:0] code);
        field_t f;
        case (code)
            SEL_B0, SEL_B1, SEL_B2, SEL_B3: begin
                f.lsb   = POS_W'({code[1:0], 3'b000});
                f.width = LEN_W'(8);
            end
            SEL_H0, SEL_H1: begin
                f.lsb   = POS_W'({code[0], 4'b0000});
                f.width = LEN_W'(16);
            end
            default: begin
                f.lsb   = '0;
                f.width = LEN_W'(WORD_W);
            end
        endcase
        return f;
    endfunction

    // Mask of `width` ones aligned at bit 0.
    function automatic logic [WORD_W-1:0] low_ones(input logic [LEN_W-1:0] width);
        logic [WORD_W:0] wide;
        wide = (WORD_W+1)'(1) << width;
        return WORD_W'(wide - (WORD_W+1)'(1));
    endfunction
endpackage

// File: rtl/sdw_extract.sv
// Source extractor: picks a byte, halfword or the whole word out of a source
// and widens it to a full word with zeros or with its own top bit.
// Assumes the select code follows sdw_pkg::sel_e; purely combinational.
module sdw_extract
    import sdw_pkg::*;
(
    input  logic [WORD_W-1:0] src,
    input  logic [2:0]        sel,
    input  logic              sext,
    output logic [WORD_W-1:0] op
);
    field_t            fld;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] keep_mask;
    logic [POS_W-1:0]  top_pos;
    logic              top_bit;

    // Locate the field and align it to bit 0.
    always_comb begin
        fld       = decode_field(sel);
        shifted   = src >> fld.lsb;
        keep_mask = low_ones(fld.width);
        top_pos   = POS_W'(fld.width - LEN_W'(1));
        top_bit   = shifted[top_pos];
    end

    // Widen: keep the field, fill above it by the sign flag (no room above a whole word).
    always_comb begin
        op = shifted & keep_mask;
        if (sext && top_bit) begin
            op = op | ~keep_mask;
        end
    end
endmodule

// File: rtl/sdw_merge.sv
// Destination merger: writes the low bits of the result into the selected
// field and fills the rest by the chosen policy (zero, sign-above, keep).
// Assumes sdw_pkg codes; purely combinational.
module sdw_merge
    import sdw_pkg::*;
(
    input  logic [WORD_W-1:0] res,
    input  logic [WORD_W-1:0] old,
    input  logic [2:0]        sel,
    input  logic [1:0]        fill,
    output logic [WORD_W-1:0] dst
);
    field_t            fld;
    logic [WORD_W-1:0] width_mask;
    logic [WORD_W-1:0] field_mask;
    logic [WORD_W-1:0] below_mask;
    logic [WORD_W-1:0] above_mask;
    logic [WORD_W-1:0] placed;
    logic [POS_W-1:0]  top_pos;
    logic              res_top;

    // Build the field, below and above masks and the placed result field.
    always_comb begin
        fld        = decode_field(sel);
        width_mask = low_ones(fld.width);
        field_mask = width_mask << fld.lsb;
        below_mask = low_ones(LEN_W'(fld.lsb));
        above_mask = ~(field_mask | below_mask);
        placed     = (res & width_mask) << fld.lsb;
        top_pos    = POS_W'(fld.width - LEN_W'(1));
        res_top    = res[top_pos];
    end

    // Combine the placed field with the bits chosen by the fill policy.
    always_comb begin
        case (fill)
            FILL_ZERO: dst = placed;
            FILL_SIGN: dst = placed | (res_top ? above_mask : '0);
            default:   dst = placed | (old & ~field_mask);
        endcase
    end
endmodule

// File: rtl/subdword_sel_merge.sv
// Top: two source extractors, one destination merger, and an optional
// output register stage chosen by OUT_REG (synchronous active-low reset).
// Assumes a 32-bit lane; the lane operation itself lives outside.
module subdword_sel_merge
    import sdw_pkg::*;
#(
    parameter bit OUT_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] src0_i,
    input  logic [WORD_W-1:0] src1_i,
    input  logic [2:0]        sel0_i,
    input  logic [2:0]        sel1_i,
    input  logic              sext0_i,
    input  logic              sext1_i,
    input  logic [WORD_W-1:0] res_i,
    input  logic [WORD_W-1:0] old_i,
    input  logic [2:0]        dsel_i,
    input  logic [1:0]        fill_i,
    output logic [WORD_W-1:0] op0_o,
    output logic [WORD_W-1:0] op1_o,
    output logic [WORD_W-1:0] dst_o
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][WORD_W-1:0] src_v;
    logic [NUM_SRC-1:0][2:0]        sel_v;
    logic [NUM_SRC-1:0]             sext_v;
    logic [NUM_SRC-1:0][WORD_W-1:0] op_v;
    logic [WORD_W-1:0]              dst_c;

    assign src_v  = {src1_i, src0_i};
    assign sel_v  = {sel1_i, sel0_i};
    assign sext_v = {sext1_i, sext0_i};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        sdw_extract u_ext (
            .src  (src_v[i]),
            .sel  (sel_v[i]),
            .sext (sext_v[i]),
            .op   (op_v[i])
        );
    end

    sdw_merge u_merge (
        .res  (res_i),
        .old  (old_i),
        .sel  (dsel_i),
        .fill (fill_i),
        .dst  (dst_c)
    );

    // Input view aligned with the outputs, used only by the checks below.
    logic [WORD_W-1:0] a_src0, a_src1, a_res, a_old;
    logic [2:0]        a_sel0, a_sel1, a_dsel;
    logic              a_sext1;
    logic [1:0]        a_fill;
    logic              primed;

    if (OUT_REG) begin : g_reg
        // Output stage: capture extracted operands and merged word each cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                op0_o <= '0;
                op1_o <= '0;
                dst_o <= '0;
            end else begin
                op0_o <= op_v[0];
                op1_o <= op_v[1];
                dst_o <= dst_c;
            end
        end

        // Delayed input copy so checks compare outputs with their own inputs.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                primed  <= 1'b0;
                a_src0  <= '0;
                a_src1  <= '0;
                a_res   <= '0;
                a_old   <= '0;
                a_sel0  <= '0;
                a_sel1  <= '0;
                a_dsel  <= '0;
                a_sext1 <= 1'b0;
                a_fill  <= '0;
            end else begin
                primed  <= 1'b1;
                a_src0  <= src0_i;
                a_src1  <= src1_i;
                a_res   <= res_i;
                a_old   <= old_i;
                a_sel0  <= sel0_i;
                a_sel1  <= sel1_i;
                a_dsel  <= dsel_i;
                a_sext1 <= sext1_i;
                a_fill  <= fill_i;
            end
        end
    end else begin : g_comb
        assign op0_o   = op_v[0];
        assign op1_o   = op_v[1];
        assign dst_o   = dst_c;
        assign primed  = 1'b1;
        assign a_src0  = src0_i;
        assign a_src1  = src1_i;
        assign a_res   = res_i;
        assign a_old   = old_i;
        assign a_sel0  = sel0_i;
        assign a_sel1  = sel1_i;
        assign a_dsel  = dsel_i;
        assign a_sext1 = sext1_i;
        assign a_fill  = fill_i;
    end

    // R2
    full_src_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && a_sel0 == SEL_FULL) |-> (op0_o == a_src0));

    // R3
    byte3_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && a_sel1 == SEL_B3 && a_sext1) |-> (op1_o == {{24{a_src1[31]}}, a_src1[31:24]}));

    // R6
    pad_outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && a_dsel == SEL_B1 && a_fill == FILL_ZERO) |-> (dst_o[31:16] == '0 && dst_o[7:0] == '0));

    // R7
    sign_fill_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && a_dsel == SEL_H0 && a_fill == FILL_SIGN) |-> (dst_o[31:16] == {16{a_res[15]}}));

    // R8
    keep_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && a_dsel == SEL_H1 && a_fill == FILL_KEEP) |-> (dst_o[15:0] == a_old[15:0]));

    // R9
    full_dst_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && a_dsel == SEL_FULL) |-> (dst_o == a_res));
endmodule

// File: tb/subdword_sel_merge_bench.sv
// Bench: sweeps every select code, sign flag and fill policy on the
// registered variant, with expected words computed arithmetically.
module subdword_sel_merge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src0, src1, res, old;
    logic [2:0]  sel0, sel1, dsel;
    logic        sext0, sext1;
    logic [1:0]  fill;
    logic [31:0] op0, op1, dst;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    subdword_sel_merge #(.OUT_REG(1'b1)) u_subdword_sel_merge (
        .clk(clk), .rst_n(rst_n),
        .src0_i(src0), .src1_i(src1), .sel0_i(sel0), .sel1_i(sel1),
        .sext0_i(sext0), .sext1_i(sext1), .res_i(res), .old_i(old),
        .dsel_i(dsel), .fill_i(fill),
        .op0_o(op0), .op1_o(op1), .dst_o(dst)
    );

    function automatic void geom(input int code, output int lsb, output int w);
        if (code < 4)      begin lsb = 8 * code;        w = 8;  end
        else if (code < 6) begin lsb = 16 * (code - 4); w = 16; end
        else               begin lsb = 0;               w = 32; end
    endfunction

    function automatic logic [31:0] exp_ext(input logic [31:0] s, input int code, input bit sx);
        int lsb, w;
        longint v;
        geom(code, lsb, w);
        if (w == 32) return s;
        v = (longint'(s) / (64'd1 << lsb)) % (64'd1 << w);
        if (sx && v >= (64'd1 << (w - 1))) v = v + (64'd1 << 32) - (64'd1 << w);
        return 32'(v);
    endfunction

    function automatic logic [31:0] exp_mrg(input logic [31:0] r, input logic [31:0] o,
                                            input int code, input int pol);
        int lsb, w;
        longint fv, top, base;
        geom(code, lsb, w);
        if (w == 32) return r;
        fv   = longint'(r) % (64'd1 << w);
        base = fv * (64'd1 << lsb);
        top  = 64'd1 << (lsb + w);
        if (pol == 1) begin
            if (fv >= (64'd1 << (w - 1))) base = base + (64'd1 << 32) - top;
        end else if (pol != 0) begin
            base = base + longint'(o) - (longint'(o) % top) + (longint'(o) % (64'd1 << lsb));
        end
        return 32'(base);
    endfunction

    function automatic logic [31:0] pat(input int k);
        case (k % 4)
            0: return 32'h80FF_7F01;
            1: return 32'h7F80_01FE;
            2: return 32'hFFFF_FFFF;
            default: return 32'h1234_8765;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        src0 = 32'hA5A5_A5A5; src1 = 32'h5A5A_5A5A; res = 32'hFFFF_FFFF; old = 32'hFFFF_FFFF;
        sel0 = 3'd0; sel1 = 3'd0; dsel = 3'd0; sext0 = 1'b1; sext1 = 1'b1; fill = 2'd1;
        repeat (3) @(posedge clk);
        #2;
        // R11: reset state clears outputs
        check("R11 reset op0", op0, 32'h0);
        check("R11 reset op1", op1, 32'h0);
        check("R11 reset dst", dst, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 R3 R4 R10: every source select with both sign flags and several patterns
        for (int s = 0; s < 8; s++) begin
            for (int x = 0; x < 2; x++) begin
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    src0 = pat(k); src1 = ~pat(k + 1) ^ 32'h0F0F_F0F0;
                    sel0 = 3'(s); sel1 = 3'((s + 3) % 8);
                    sext0 = x[0]; sext1 = ~x[0];
                    @(posedge clk); #2;
                    check($sformatf("R1/R2/R3/R10 op0 sel=%0d sx=%0d", s, x), op0, exp_ext(src0, s, x[0]));
                    check($sformatf("R4 op1 sel=%0d sx=%0d", (s + 3) % 8, 1 - x), op1,
                          exp_ext(src1, (s + 3) % 8, ~x[0]));
                end
            end
        end

        // R5 R6 R7 R8 R9 R10: every destination select against every fill policy
        for (int d = 0; d < 8; d++) begin
            for (int p = 0; p < 4; p++) begin
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    res = pat(k + 2) ^ {28'h0, 4'(k)};
                    old = (k % 2 == 0) ? 32'hFFFF_FFFF : 32'hC3A5_5A3C;
                    dsel = 3'(d); fill = 2'(p);
                    @(posedge clk); #2;
                    check($sformatf("R5/R6/R7/R8/R9/R10 dst sel=%0d pol=%0d", d, p), dst,
                          exp_mrg(res, old, d, p));
                end
            end
        end

        // R11: output holds until the next rising edge, then updates
        @(negedge clk);
        res = 32'h0000_00AB; dsel = 3'd6; fill = 2'd0;
        @(posedge clk); #2;
        check("R11 settle", dst, 32'h0000_00AB);
        @(negedge clk);
        res = 32'h1111_2222;
        #1;
        check("R11 hold before edge", dst, 32'h0000_00AB);
        @(posedge clk); #2;
        check("R11 update after edge", dst, 32'h1111_2222);

        // R11: synchronous reset mid-run clears outputs at the next edge
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2;
        check("R11 sync reset dst", dst, 32'h0);
        check("R11 sync reset op0", op0, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule